// File: doc/BRIEF.md
# Second-Order 17-Level Noise-Shaping Modulator with Triangular Dither

This block turns a stream of oversampled signed audio words, one per modulator update at 128 times the audio word rate, into a 5-bit level code for a unit-element DAC. Two cascaded integrators shape the quantization error toward high frequencies, and a 17-level quantizer replaces the usual one-bit comparator. The quantizer output is fed back as a signed level `(code - 8)` times one step. Code 8 stands for zero, code 0 for minus eight steps and code 16 for plus eight steps.

The step is 2^(IN_W-4), which is 2^16 for the default 20-bit input. With this step, eight steps span the full input scale. When `dither_en` is high, a triangular-PDF dither value is added at the quantizer input. The dither is the sum of two uniform values, each from its own 16-bit maximal-length LFSR with its own polynomial and nonzero seed. The dither stays strictly inside plus or minus one step.

Each channel uses its own instance. The upstream interpolator raises `in_valid` once per oversampled word. The downstream element-matching logic takes the code when `code_valid` is high. `rst` is a synchronous reset.

Top module: `sdm17_modulator`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `code` = 8 and `code_valid` = 0. Both integrators return to zero and both LFSRs return to their seeds. As a result, any stimulus sequence applied after reset yields the same code sequence every time.
- R2: `code_valid` is high in exactly the cycle after an edge where `in_valid` was high. After an edge with `in_valid` low, `code` holds and no loop or dither state advances, so idle cycles inserted between words leave the code sequence unchanged.
- R3: `code` is an unsigned 5-bit value that never exceeds 16, whatever the input and dither.
- R4: The feedback for each code is (code - 8) times 2^(IN_W-4). With dither off and a zero input from reset, every code is 8.
- R5: The loop is second order with output y[n] = x[n-1] + (1 - z^-1)^2 e[n]. Starting from reset, a constant input of exactly one step gives the code 8 first and then 9 on every following word.
- R6: With dither on, the added dither lies strictly between minus one step and plus one step. With dither on and a zero input, the codes are not all 8, but over 256 words the sum of (code - 8) stays within 12 of zero.
- R7: For a constant input x, the sum of (code - 8) over 256 words after reset lies within 12 of x·256/2^(IN_W-4). This holds up to both full-scale inputs, with or without dither, because the ACC_W-bit integrators saturate rather than wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking an oversampled input word |
| in_sample | input | IN_W | Signed two's complement input word |
| dither_en | input | 1 | Adds triangular dither at the quantizer input when high |
| code_valid | output | 1 | High for one cycle with each new code |
| code | output | 5 | Quantizer level code, 0 to 16, with 8 meaning zero |

## Verification
The assertions assume that `in_valid`, `in_sample` and `dither_en` are settled at every rising edge. They also assume that `rst` is high at the first edge, so the reset-state property never sees undriven state. The bench changes every input only at falling edges and holds `rst` high from time zero. It keeps `in_sample` inside the 20-bit signed range, so the no-wrap properties are checked only against increments the loop can really produce.

// File: rtl/sdm17_modulator.sv
module sdm17_modulator #(
  parameter int IN_W  = 20,
  parameter int ACC_W = 26
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_sample,
  input  logic                   dither_en,
  output logic                   code_valid,
  output logic [4:0]             code
);
  localparam int SL  = IN_W - 4;
  localparam int W   = ACC_W + 2;
  localparam int LW  = 16;
  localparam int QW  = W - SL;
  localparam logic signed [ACC_W-1:0] AMAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] AMIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [LW-1:0] SEED_A = 16'hACE1;
  localparam logic [LW-1:0] SEED_B = 16'h1D2B;

  logic signed [ACC_W-1:0] i1, i2, i1n, i2n;
  logic [LW-1:0]           la, lb;
  logic signed [W-1:0]     xw, lvl, fbw, i1_raw, i2_raw, ua, ub, dith, qin;
  logic signed [QW-1:0]    qv;
  logic [4:0]              qcode;

  function automatic logic signed [ACC_W-1:0] sat(input logic signed [W-1:0] v);
    if (v > W'(AMAX)) return AMAX;
    else if (v < W'(AMIN)) return AMIN;
    else return ACC_W'(v);
  endfunction

  assign ua   = W'($signed(la)) <<< (SL - LW);
  assign ub   = W'($signed(lb)) <<< (SL - LW);
  assign dith = dither_en ? (ua + ub) : '0;

  assign qin  = W'(i2) + dith + (W'(1) <<< (SL - 1));
  assign qv   = QW'(qin >>> SL);

  always_comb begin
    if (qv < -8)      qcode = 5'd0;
    else if (qv > 8)  qcode = 5'd16;
    else              qcode = 5'(qv + QW'(8));
  end

  assign lvl    = $signed({{(W-5){1'b0}}, qcode}) - W'(8);
  assign fbw    = lvl <<< SL;
  assign xw     = W'(in_sample);
  assign i1_raw = W'(i1) + xw - fbw;
  assign i1n    = sat(i1_raw);
  assign i2_raw = W'(i2) + W'(i1n) - fbw;
  assign i2n    = sat(i2_raw);

  always_ff @(posedge clk) begin
    if (rst) begin
      i1         <= '0;
      i2         <= '0;
      la         <= SEED_A;
      lb         <= SEED_B;
      code       <= 5'd8;
      code_valid <= 1'b0;
    end else begin
      code_valid <= in_valid;
      if (in_valid) begin
        i1   <= i1n;
        i2   <= i2n;
        la   <= {la[LW-2:0], la[15] ^ la[13] ^ la[12] ^ la[10]};
        lb   <= {lb[LW-2:0], lb[15] ^ lb[14] ^ lb[12] ^ lb[3]};
        code <= qcode;
      end
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (code == 5'd8 && !code_valid));                                    // R1
  AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> code_valid);                                                  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!code_valid && $stable(code)));                             // R2
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    code <= 5'd16);                                                            // R3
  AST_DITHER_PEAK: assert property (@(posedge clk) disable iff (rst)
    (dith > -(W'(1) <<< SL)) && (dith < (W'(1) <<< SL)));                      // R6
  AST_I1_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && i1 >= 0 && (xw - fbw) >= 0) |=> (i1 >= $past(i1)));           // R7
  AST_I1_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && i1 < 0 && (xw - fbw) <= 0) |=> (i1 <= $past(i1)));            // R7
endmodule

// File: tb/tb_sdm17_modulator.sv
`timescale 1ns/1ps
module tb_sdm17_modulator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [19:0] in_sample = '0;
  logic dither_en = 1'b0;
  logic code_valid;
  logic [4:0] code;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  sdm17_modulator dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .dither_en(dither_en), .code_valid(code_valid), .code(code)
  );

  always #10 clk = ~clk;

  localparam int NT = 13;
  localparam int STEP = 65536;
  localparam int TOL = 12;
  localparam int TX [NT] = '{0, 65536, -65536, 163840, -131072, 16384, 300000,
                             524287, -524288, 0, 98304, -250000, 524287};
  localparam int TD [NT] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1};
  localparam int TE [NT] = '{0, 256, -256, 640, -512, 64, 1172,
                             2048, -2048, 0, 384, -977, 2048};

  int range_bad = 0;
  int seq_a [40];
  int seq_b [40];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input int x, output int c);
    in_valid = 1'b1;
    in_sample = 20'(x);
    @(negedge clk);
    in_valid = 1'b0;
    c = int'(code);
    if (code > 5'd16) range_bad++;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c;
    int s;
    int mism;
    int diff;
    bit saw_other;

    repeat (3) @(negedge clk);
    chk(code == 5'd8, "R1 reset code", int'(code), 8);
    chk(code_valid == 1'b0, "R1 reset valid", int'(code_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NT; k++) begin
      do_reset();
      dither_en = TD[k][0];
      s = 0;
      for (int n = 0; n < 256; n++) begin
        send(TX[k], c);
        s += c - 8;
      end
      diff = s - TE[k];
      chk(diff <= TOL && diff >= -TOL, $sformatf("R7 dc sum entry %0d", k), s, TE[k]);
    end
    dither_en = 1'b0;

    do_reset();
    mism = 0;
    for (int n = 0; n < 64; n++) begin
      send(0, c);
      if (c != 8) mism++;
    end
    chk(mism == 0, "R4 zero input codes not 8", mism, 0);

    do_reset();
    mism = 0;
    for (int n = 0; n < 12; n++) begin
      send(STEP, c);
      if (c != ((n == 0) ? 8 : 9)) mism++;
    end
    chk(mism == 0, "R5 one-step response mismatches", mism, 0);

    do_reset();
    send(STEP, c);
    chk(code_valid == 1'b1, "R2 valid after word", int'(code_valid), 1);
    idle(1);
    chk(code_valid == 1'b0, "R2 valid low when idle", int'(code_valid), 0);
    chk(int'(code) == c, "R2 code holds when idle", int'(code), c);

    dither_en = 1'b1;
    do_reset();
    for (int n = 0; n < 40; n++) begin
      send(98304, c);
      seq_a[n] = c;
    end
    do_reset();
    for (int n = 0; n < 40; n++) begin
      send(98304, c);
      seq_b[n] = c;
      if (n % 3 == 0) idle(2);
    end
    mism = 0;
    for (int n = 0; n < 40; n++) if (seq_a[n] != seq_b[n]) mism++;
    chk(mism == 0, "R2 idle gaps changed sequence", mism, 0);

    do_reset();
    saw_other = 1'b0;
    for (int n = 0; n < 40; n++) begin
      send(0, c);
      seq_a[n] = c;
      if (c != 8) saw_other = 1'b1;
    end
    chk(saw_other, "R6 dither moved codes", int'(saw_other), 1);
    for (int n = 0; n < 100; n++) send(300000, c);
    do_reset();
    mism = 0;
    for (int n = 0; n < 40; n++) begin
      send(0, c);
      if (c != seq_a[n]) mism++;
    end
    chk(mism == 0, "R1 dither state not restored", mism, 0);
    dither_en = 1'b0;

    chk(range_bad == 0, "R3 codes above 16", range_bad, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule